// File: doc/BRIEF.md
# Byte Mailbox Bridge Between a Host I/O Bus and a Target Device

This block lets a host CPU and a target device exchange single bytes through two host I/O addresses. The host writes a byte to the data address. That write loads an outbound register and raises a busy flag, which drives a strobe line to the target. The target takes the byte. It then answers by pulsing its acknowledge line with its reply on the inbound bus.

That one acknowledge pulse does three jobs. While the line is high, the outbound byte driver is disabled. When the line falls, the reply byte is captured into the inbound latch. The same fall clears the busy flag and the strobe. The host polls the status address until the busy bit drops, then reads the data address to collect the reply.

The base address comes from a 2-bit jumper code and can be one of four 16-byte-aligned locations. With all jumpers open (code 00) the base is 0x320. The acknowledge line is asynchronous to the bus clock and is synchronized before use.

Top module: `byte_mailbox`

## Requirements
- R1: The base address depends on `jumper_sel`: 00 selects 0x320, 01 selects 0x330, 10 selects 0x300, 11 selects 0x310. The data port is at the base and the status port is at base+2. A read of any other address returns 0.
- R2: A host write (`io_wr`) to the data port loads `io_wdata` into the outbound register and sets the busy flag. From the next clock edge, `tgt_dout` shows the byte and `tgt_strobe` is high.
- R3: A host read (`io_rd`) of the status port returns the busy flag in bit 0, with bits 7..1 reading 0. Read data is combinational in the cycle `io_rd` is high.
- R4: `tgt_dout_oe` is low from the second clock edge after `tgt_ack` rises. It returns high at the second clock edge after `tgt_ack` falls.
- R5: A fall of `tgt_ack` captures `tgt_din` into the inbound latch at the third clock edge after the fall. The target must keep `tgt_din` steady until then.
- R6: The same acknowledge fall event clears the busy flag. The strobe and the status bit therefore drop at that edge.
- R7: A host read of the data port returns the inbound latch, never the outbound register.
- R8: When a data-port write and an acknowledge fall event fall in the same cycle, the busy flag ends up set. The new byte is loaded, and the inbound latch still captures the reply.
- R9: While `rst_n` is low, the busy flag, the strobe and both byte registers are cleared. `tgt_dout_oe` is high and every read returns 0.
- R10: A write to the status port, or to any address other than the data port, changes neither the outbound byte nor the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| jumper_sel | input | 2 | Base address selection code |
| io_addr | input | 10 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| tgt_dout | output | 8 | Outbound byte to the target |
| tgt_dout_oe | output | 1 | Output enable for the outbound byte driver |
| tgt_strobe | output | 1 | Byte-available strobe to the target (busy flag) |
| tgt_din | input | 8 | Reply byte from the target |
| tgt_ack | input | 1 | Target acknowledge line, idle low, pulsed high |

## Verification
The bench builds the block with its default parameters. These are a 10-bit address, 8-bit data, a two-stage acknowledge synchronizer, 16-byte base spacing and a status offset of 2.

With these values, all four jumper codes map to real addresses. Random exchanges therefore move across every base. Stray writes land next to each decoded port.

Because the synchronizer depth is fixed at two, the bench can place a host write on exactly the edge where the acknowledge fall is acted on. That brings the write-wins collision and the exact output-enable timing within reach of directed checks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Which host port an access targets
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_STATUS = 2'd2
  } mbx_sel_e;

  // Jumper code to base slot; open jumpers (00) pick slot 2
  function automatic logic [1:0] jumper_slot(input logic [1:0] code);
    return code ^ 2'b10;
  endfunction

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec #(
  parameter int ADDR_W     = 10,
  parameter int BASE_ROOT  = 'h300,
  parameter int BASE_STEP  = 'h10,
  parameter int STATUS_OFS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        jumper_sel,
  output mbx_pkg::mbx_sel_e sel
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] ROOT_A = ADDR_W'(BASE_ROOT);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BASE_STEP);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);

  logic [ADDR_W-1:0] base_a;
  logic [ADDR_W-1:0] stat_a;

  always_comb begin
    base_a = ROOT_A + (ADDR_W'(jumper_slot(jumper_sel)) * STEP_A);
    stat_a = base_a + STAT_A;
  end

  always_comb begin
    if (addr == base_a)      sel = SEL_DATA;
    else if (addr == stat_a) sel = SEL_STATUS;
    else                     sel = SEL_NONE;
  end

endmodule

// File: rtl/mbx_ack_sync.sv
module mbx_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  output logic ack_level,
  output logic ack_fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= ack_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign ack_level = sync_q[STAGES-1];
  assign ack_fall  = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/mbx_core.sv
module mbx_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbx_pkg::mbx_sel_e sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_fall,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] out_byte,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);
  import mbx_pkg::*;

  logic              load_en;
  logic [DATA_W-1:0] out_q, out_d;
  logic [DATA_W-1:0] in_q,  in_d;
  logic              busy_q, busy_d;
  logic              busy_en;

  assign load_en = wr && (sel == SEL_DATA);
  assign busy_en = load_en | ack_fall;

  // next state
  always_comb begin
    out_d  = wdata;
    in_d   = din;
    busy_d = busy_q;
    if (ack_fall) busy_d = 1'b0;
    if (load_en)  busy_d = 1'b1;   // host write wins a collision
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (load_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_q <= '0;
    else if (ack_fall) in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_DATA:   rdata = in_q;
        SEL_STATUS: rdata = {{(DATA_W-1){1'b0}}, busy_q};
        default:    rdata = '0;
      endcase
    end
  end

  assign out_byte = out_q;
  assign busy     = busy_q;

endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int BASE_ROOT   = 'h300,
  parameter int BASE_STEP   = 'h10,
  parameter int STATUS_OFS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        jumper_sel,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] tgt_dout,
  output logic              tgt_dout_oe,
  output logic              tgt_strobe,
  input  logic [DATA_W-1:0] tgt_din,
  input  logic              tgt_ack
);
  import mbx_pkg::*;

  mbx_sel_e sel;
  logic     ack_level;
  logic     ack_fall;
  logic     busy;

  mbx_addr_dec #(
    .ADDR_W     (ADDR_W),
    .BASE_ROOT  (BASE_ROOT),
    .BASE_STEP  (BASE_STEP),
    .STATUS_OFS (STATUS_OFS)
  ) u_dec (
    .addr       (io_addr),
    .jumper_sel (jumper_sel),
    .sel        (sel)
  );

  mbx_ack_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_in    (tgt_ack),
    .ack_level (ack_level),
    .ack_fall  (ack_fall)
  );

  mbx_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wr       (io_wr),
    .rd       (io_rd),
    .wdata    (io_wdata),
    .ack_fall (ack_fall),
    .din      (tgt_din),
    .out_byte (tgt_dout),
    .busy     (busy),
    .rdata    (io_rdata)
  );

  assign tgt_strobe  = busy;
  assign tgt_dout_oe = ~ack_level;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int BASE_ROOT  = 'h300,
  parameter int BASE_STEP  = 'h10,
  parameter int STATUS_OFS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        jumper_sel,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic [DATA_W-1:0] tgt_dout,
  input logic              tgt_dout_oe,
  input logic              tgt_strobe,
  input logic              tgt_ack
);
  logic [ADDR_W-1:0] data_a;
  logic [ADDR_W-1:0] stat_a;
  logic [1:0]        age_q;
  logic              armed;

  assign data_a = ADDR_W'(BASE_ROOT) + ADDR_W'(mbx_pkg::jumper_slot(jumper_sel)) * ADDR_W'(BASE_STEP);
  assign stat_a = data_a + ADDR_W'(STATUS_OFS);
  assign armed  = (age_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= 2'd0;
    else if (!armed) age_q <= age_q + 2'd1;
  end

  // R2: a data-port write shows the byte and raises strobe next edge
  p_write_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == data_a) |=> (tgt_strobe && tgt_dout == $past(io_wdata)));

  // R3: status padding bits read zero
  p_status_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == stat_a) |-> (io_rdata[DATA_W-1:1] == '0));

  // R4: driver disabled after ack held high for two sampled edges
  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(tgt_ack) && $past(tgt_ack, 2)) |-> !tgt_dout_oe);

  // R6: strobe only drops once the ack line has been seen low
  p_strobe_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(tgt_strobe)) |-> (!$past(tgt_ack) && !$past(tgt_ack, 2)));

  // R10: writes elsewhere leave the outbound byte alone
  p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != data_a) |=> (tgt_dout == $past(tgt_dout)));

endmodule

bind byte_mailbox mbx_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BASE_ROOT  (BASE_ROOT),
  .BASE_STEP  (BASE_STEP),
  .STATUS_OFS (STATUS_OFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .jumper_sel  (jumper_sel),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .tgt_dout    (tgt_dout),
  .tgt_dout_oe (tgt_dout_oe),
  .tgt_strobe  (tgt_strobe),
  .tgt_ack     (tgt_ack)
);

// File: tb/byte_mailbox_bench.sv
module byte_mailbox_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] jumper_sel;
  logic [9:0] io_addr;
  logic       io_wr, io_rd;
  logic [7:0] io_wdata, io_rdata;
  logic [7:0] tgt_dout, tgt_din;
  logic       tgt_dout_oe, tgt_strobe, tgt_ack;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_out, exp_in;
  logic       exp_busy;

  always #10 clk = ~clk;   // 50 MHz

  byte_mailbox u_byte_mailbox (
    .clk(clk), .rst_n(rst_n), .jumper_sel(jumper_sel),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .tgt_dout(tgt_dout), .tgt_dout_oe(tgt_dout_oe),
    .tgt_strobe(tgt_strobe), .tgt_din(tgt_din), .tgt_ack(tgt_ack)
  );

  function automatic logic [9:0] base_of(input logic [1:0] code);
    case (code)
      2'b00:   return 10'h320;
      2'b01:   return 10'h330;
      2'b10:   return 10'h300;
      default: return 10'h310;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic host_read(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic ack_reply(input logic [7:0] d);
    @(negedge clk);
    tgt_ack = 1'b1; tgt_din = d;
    repeat (3) @(negedge clk);
    chk(tgt_dout_oe == 1'b0, "R4 oe off during ack", tgt_dout_oe, 0);
    tgt_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(tgt_dout_oe == 1'b1, "R4 oe back after ack fall", tgt_dout_oe, 1);
    repeat (2) @(negedge clk);
    tgt_din = 8'($urandom);
    exp_in = d; exp_busy = 1'b0;
  endtask

  task automatic check_state(input string tag);
    logic [7:0] v;
    logic [9:0] b;
    b = base_of(jumper_sel);
    host_read(b + 10'd2, v);
    chk(v == {7'd0, exp_busy}, {"R3 status ", tag}, v, {7'd0, exp_busy});
    host_read(b, v);
    chk(v == exp_in, {"R7 data read ", tag}, v, exp_in);
    chk(tgt_strobe == exp_busy, {"R6 strobe ", tag}, tgt_strobe, exp_busy);
    chk(tgt_dout == exp_out, {"R10 dout ", tag}, tgt_dout, exp_out);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [9:0] b;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; jumper_sel = 2'b00; io_addr = '0; io_wr = 0; io_rd = 0;
    io_wdata = '0; tgt_din = '0; tgt_ack = 1'b0;
    exp_out = '0; exp_in = '0; exp_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk(tgt_strobe == 0 && tgt_dout == 0 && tgt_dout_oe == 1, "R9 reset outputs",
        {tgt_strobe, tgt_dout_oe, tgt_dout}, 10'h100);
    rst_n = 1'b1;
    check_state("after reset R9");

    // directed exchange at default base 0x320
    host_write(10'h320, 8'hA5);
    exp_out = 8'hA5; exp_busy = 1'b1;
    chk(tgt_strobe == 1 && tgt_dout == 8'hA5, "R2 write loads and strobes",
        {tgt_strobe, tgt_dout}, 9'h1A5);
    check_state("busy, data port shows inbound R7");
    ack_reply(8'h3C);
    check_state("after reply R5 R6");

    // stray writes R10 and unmapped read R1
    host_write(10'h322, 8'hFF);
    host_write(10'h321, 8'h11);
    host_write(10'h330, 8'h22);
    check_state("stray writes R10");
    host_read(10'h324, v);
    chk(v == 8'h00, "R1 unmapped read", v, 0);

    // base selection R1
    jumper_sel = 2'b10;
    host_write(10'h320, 8'h77);
    chk(tgt_strobe == 0, "R1 old base ignored", tgt_strobe, 0);
    host_write(10'h300, 8'h5A);
    exp_out = 8'h5A; exp_busy = 1'b1;
    chk(tgt_strobe == 1 && tgt_dout == 8'h5A, "R1 base 0x300 decoded",
        {tgt_strobe, tgt_dout}, 9'h15A);
    ack_reply(8'hC3);
    check_state("base 0x300 R1");

    // collision R8: write lands on the fall-event edge
    @(negedge clk);
    tgt_ack = 1'b1; tgt_din = 8'h96;
    repeat (3) @(negedge clk);
    tgt_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    io_addr = 10'h300; io_wdata = 8'h69; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    exp_out = 8'h69; exp_in = 8'h96; exp_busy = 1'b1;
    chk(tgt_strobe == 1, "R8 write wins busy", tgt_strobe, 1);
    check_state("collision R8");
    ack_reply(8'h0F);
    check_state("after collision");

    // random exchanges
    for (int i = 0; i < 40; i++) begin
      logic [7:0] wb, rb;
      jumper_sel = 2'($urandom);
      b  = base_of(jumper_sel);
      wb = 8'($urandom);
      rb = 8'($urandom);
      host_write(b, wb);
      exp_out = wb; exp_busy = 1'b1;
      chk(tgt_dout == wb && tgt_strobe, "R2 random write", {tgt_strobe, tgt_dout}, {1'b1, wb});
      host_write((i % 2) ? b + 10'd1 : b ^ 10'h040, 8'($urandom));
      check_state("random busy R10");
      ack_reply(rb);
      check_state("random reply R5");
    end

    // reset while busy R9
    host_write(base_of(jumper_sel), 8'hEE);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tgt_strobe == 0 && tgt_dout == 0, "R9 reset clears busy state",
        {tgt_strobe, tgt_dout}, 0);
    rst_n = 1'b1;
    exp_out = '0; exp_in = '0; exp_busy = 1'b0;
    check_state("after mid reset R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule